// File: doc/BRIEF.md
# Four-Stage Feedback Sequence Generator

This block is a small pseudo-random bit source. It holds a four-bit state that shifts one place toward the low end on every clock. The bit that enters at the top is the exclusive-OR of the two lowest state bits, and that same bit is brought out as the sequence output. Because this feedback is maximal for four stages, every nonzero state appears once before the pattern repeats. The output therefore repeats with a period of 15 clocks.

A host selects between two modes with one control input. While the load input is high, each clock copies the seed input into the state. While it is low, the generator free-runs. The all-zero state would hold the register at zero for ever. The block detects that state and replaces it with the default seed 1111 on the next free-running clock. It also has an active-low synchronous reset that places the state at the default seed.

Top module: `seqgen_lfsr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state `q` becomes 1111 (the default seed).
- R2: The output `y` always equals `q[1]` XOR `q[0]` of the present state.
- R3: With `load` high, the rising edge copies `seed` into `q`. This holds for any seed value, zero included.
- R4: With `load` low and a nonzero state, the rising edge moves `q[3:1]` into `q[2:0]` and puts the previous `y` into `q[3]`.
- R5: Free-running from 1111, `q` follows the order 1111, 0111, 0011, 0001, 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, and then returns to 1111.
- R6: Any 15 consecutive free-running clocks from a nonzero state visit each of the 15 nonzero states exactly once, and the state then equals its starting value.
- R7: Over one period starting at 1111, `y` reads 0,0,0,1,0,0,1,1,0,1,0,1,1,1,1, one value per clock.
- R8: When the state is 0000 and `load` is low, the next rising edge sets `q` to 1111.
- R9: Free-running from a nonzero state never reaches 0000.
- R10: While `load` stays high with a zero seed, `q` stays at 0000, because load takes priority over zero recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset to the default seed |
| load | input | 1 | 1: copy `seed` into the state; 0: free-run |
| seed | input | WIDTH (4) | Value that is loaded while `load` is high |
| q | output | WIDTH (4) | Present state, bit 3 is the entry stage |
| y | output | 1 | Feedback / sequence bit, XOR of `q[1]` and `q[0]` |

## Verification
The bench uses the default parameters: a width of 4 and a default seed of 1111. These are the values for which the two-lowest-bit feedback gives a maximal 15-state cycle. With them, the full state order, the output bit pattern and the visit-once property can all be checked over complete periods. The bench also runs a period from a seed other than the default. It loads a zero seed, holds it with load high, and then releases load, which exercises the lock-up recovery.

// File: rtl/seqgen_lfsr.sv
module seqgen_lfsr #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED = {WIDTH{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] q,
  output logic             y
);
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  logic [WIDTH-1:0] state;
  logic             fb;
  logic             locked;

  assign fb     = state[1] ^ state[0];
  assign locked = (state == ALL_ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= SEED;
    else if (load)   state <= seed;
    else if (locked) state <= SEED;
    else             state <= {fb, state[WIDTH-1:1]};
  end

  assign q = state;
  assign y = fb;
endmodule

// File: rtl/seqgen_lfsr_chk.sv
module seqgen_lfsr_chk #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] SEED = {WIDTH{1'b1}}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] q,
  input logic             y
);
  assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(seed)));

  assert_shift_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && q != '0) |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1]) && q[WIDTH-1] == $past(y)));

  assert_zero_recovers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && q == '0) |=> (q == SEED));

  assert_no_lockup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && q != '0) |=> (q != '0));
endmodule

bind seqgen_lfsr seqgen_lfsr_chk #(.WIDTH(WIDTH), .SEED(SEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .q(q), .y(y)
);

// File: tb/sim_seqgen_lfsr.sv
module sim_seqgen_lfsr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] seed = 4'd0;
  logic [3:0] q;
  logic       y;

  int checks = 0;
  int errors = 0;
  int model = 15;

  seqgen_lfsr u0 (.clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .q(q), .y(y));

  always #(CLK_PERIOD/2) clk = ~clk;

  int exp_q [15] = '{15, 7, 3, 1, 8, 4, 2, 9, 12, 6, 11, 5, 10, 13, 14};
  int exp_y [15] = '{0, 0, 0, 1, 0, 0, 1, 1, 0, 1, 0, 1, 1, 1, 1};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural model: integer arithmetic on the state value
  function automatic int next_of(int s, bit ld, int sd, bit rst);
    int low_two;
    if (rst) return 15;
    if (ld) return sd;
    if (s == 0) return 15;
    low_two = s % 4;
    return (s / 2) + (((low_two == 1) || (low_two == 2)) ? 8 : 0);
  endfunction

  task automatic step(input bit ld, input int sd);
    load = ld;
    seed = sd[3:0];
    @(posedge clk);
    #1;
    model = next_of(model, ld, sd, !rst_n);
    chk("R4 state vs model", int'(q), model);
    chk("R2 y parity", int'(y), ((model % 4 == 1) || (model % 4 == 2)) ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen [16];
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R1 reset state", int'(q), 15);
    rst_n = 1'b1;

    for (int p = 0; p < 2; p++) begin
      foreach (seen[i]) seen[i] = 0;
      for (int k = 0; k < 15; k++) begin
        chk("R5 state order", int'(q), exp_q[k]);
        chk("R7 y pattern", int'(y), exp_y[k]);
        seen[q]++;
        step(1'b0, 0);
      end
      for (int s = 1; s < 16; s++) chk("R6 visit once", seen[s], 1);
      chk("R6 zero never visited R9", seen[0], 0);
    end

    step(1'b1, 5);
    chk("R3 loaded seed", int'(q), 5);
    foreach (seen[i]) seen[i] = 0;
    for (int k = 0; k < 15; k++) begin
      seen[q]++;
      step(1'b0, 0);
      chk("R9 no zero in run", int'(q != 0), 1);
    end
    chk("R6 period from 0101", int'(q), 5);
    for (int s = 1; s < 16; s++) chk("R6 visit once from 0101", seen[s], 1);

    step(1'b1, 0);
    chk("R3 zero seed loaded", int'(q), 0);
    chk("R2 y at zero", int'(y), 0);
    step(1'b1, 0);
    chk("R10 load holds zero", int'(q), 0);
    step(1'b0, 0);
    chk("R8 recovery to 1111", int'(q), 15);

    step(1'b0, 0);
    step(1'b1, 9);
    chk("R3 reload mid-run", int'(q), 9);
    for (int k = 0; k < 6; k++) step(1'b0, 0);

    rst_n = 1'b0;
    step(1'b0, 0);
    chk("R1 reset mid-run", int'(q), 15);
    rst_n = 1'b1;
    step(1'b0, 0);
    chk("R5 after reset", int'(q), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule